// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Divider

This block derives one slower clock-phase signal from a reference clock. The ratio comes from an 8-bit divisor, and a duty bit controls the waveform. Software loads a new divisor and duty bit through a single-cycle write strobe. The new setting is held as pending and takes effect only when the current output period has finished. The first cycle of the new period is always a high phase, so a change never produces a shortened pulse.

While a setting is pending, a per-divider busy flag is set. A summary flag reports whether any ratio change is in progress. That summary flag includes an external signal that reports a multiplier update in progress elsewhere. A write that arrives while a change is pending is dropped, and a sticky error flag records it. When the divisor is 1, the phase output stays high and a pass-through indication tells the downstream clock selector to use the reference clock directly.

Top module: `clk_ratio_gen`

## Requirements
- R1: For an even ratio N, the output is high for N/2 reference cycles and then low for N/2 reference cycles, with the period starting on the high phase.
- R2: A divisor value of 0 selects a ratio of 256, which gives 128 cycles high and 128 cycles low.
- R3: A write with `wr_en` high while `busy` is 0 is accepted, and `busy` reads 1 from the cycle after the write.
- R4: A pending setting is applied only at a period boundary. `busy` falls in the same cycle as the first high cycle of the new period. When the old ratio was 2 or more, the cycle before that is the low end of the old period.
- R5: For an odd ratio N with `wr_hi_wide`=1, the high phase lasts (N+1)/2 cycles and the low phase lasts (N-1)/2 cycles. With `wr_hi_wide`=0, the two phase lengths are swapped.
- R6: `any_busy` is registered. After each clock edge it equals the new value of `busy` ORed with the value `pll_busy_in` had at that edge.
- R7: A write while `busy` is 1 is ignored, including a write in the very cycle the pending setting is applied, and `wr_err` becomes 1 and stays 1 until reset.
- R8: After reset, the ratio is 1 with the duty bit set, `busy`, `any_busy` and `wr_err` are 0, and `div_clk_out` and `pass_thru` are 1.
- R9: With a divisor of 1, `div_clk_out` stays constantly high and `pass_thru` is 1, whatever the duty bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a new setting |
| wr_div | input | 8 | Divisor to load (0 means 256) |
| wr_hi_wide | input | 1 | For odd ratios, 1 gives the high phase the extra cycle |
| pll_busy_in | input | 1 | External multiplier-update-in-progress indication |
| div_clk_out | output | 1 | Divided phase output (registered) |
| pass_thru | output | 1 | High when the active ratio is 1 |
| busy | output | 1 | A written setting is waiting to be applied |
| any_busy | output | 1 | Summary: busy or external update in progress |
| wr_err | output | 1 | Sticky: a write was dropped because busy was set |

## Verification
A write strobe and the application of a pending setting can occur in the same cycle. The bench provokes this from the ratio-1 state, where every cycle is a period boundary. It issues two writes on back-to-back cycles, so the second one meets the edge that applies the first. The result is judged at the ports: `busy` must be clear, `wr_err` must be set, and the waveform that follows must have the phase lengths of the first write, not the second.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  parameter int unsigned RATIO_W = 8;

  typedef struct packed {
    logic [RATIO_W-1:0] div;
    logic               hi_wide;
  } ratio_cfg_t;
endpackage

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter logic [RATIO_W-1:0] RST_DIV = 1,
  parameter logic               RST_HW  = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  ratio_cfg_t wr_cfg,
  input  logic       ext_busy,
  input  logic       wrap,
  output ratio_cfg_t act_cfg,
  output ratio_cfg_t nxt_cfg,
  output logic       busy_q,
  output logic       any_q,
  output logic       err_q
);
  ratio_cfg_t pend_cfg;
  logic       accept;
  logic       apply;
  logic       busy_d;

  // a write is taken only when nothing is pending
  assign accept = wr_en && !busy_q;
  assign apply  = busy_q && wrap;

  always_comb begin
    busy_d = busy_q;
    if (accept)     busy_d = 1'b1;
    else if (apply) busy_d = 1'b0;
  end

  // setting that governs the cycle after this edge
  assign nxt_cfg = apply ? pend_cfg : act_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_cfg  <= '{div: RST_DIV, hi_wide: RST_HW};
      pend_cfg <= '{div: RST_DIV, hi_wide: RST_HW};
      busy_q   <= 1'b0;
      any_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (accept)
        pend_cfg <= wr_cfg;
      if (wr_en && busy_q)
        err_q <= 1'b1;
      if (apply)
        act_cfg <= pend_cfg;
      busy_q <= busy_d;
      any_q  <= busy_d | ext_busy;
    end
  end
endmodule

// File: rtl/clk_ratio_core.sv
module clk_ratio_core
  import clk_ratio_pkg::*;
#(
  parameter logic [RATIO_W-1:0] RST_DIV = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  ratio_cfg_t cur_cfg,
  input  ratio_cfg_t nxt_cfg,
  output logic       wrap,
  output logic       phase_q,
  output logic       pass_q
);
  localparam int unsigned LEN_W = RATIO_W + 1;
  localparam logic [RATIO_W-1:0] ONE  = {{(RATIO_W-1){1'b0}}, 1'b1};
  localparam logic [LEN_W-1:0]   FULL = {1'b1, {RATIO_W{1'b0}}};
  localparam logic [LEN_W-1:0]   L1   = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] cnt_nxt;
  logic [RATIO_W-1:0] last;

  // number of high cycles in one period
  function automatic logic [LEN_W-1:0] hi_len(input ratio_cfg_t c);
    logic [LEN_W-1:0] n;
    n = (c.div == '0) ? FULL : {1'b0, c.div};
    if (n == L1)
      return L1;
    return c.hi_wide ? ((n + L1) >> 1) : (n >> 1);
  endfunction

  assign last    = cur_cfg.div - ONE;
  assign wrap    = (cnt == last);
  assign cnt_nxt = wrap ? '0 : cnt + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      phase_q <= 1'b1;
      pass_q  <= (RST_DIV == ONE);
    end else begin
      cnt     <= cnt_nxt;
      phase_q <= ({1'b0, cnt_nxt} < hi_len(nxt_cfg));
      pass_q  <= (nxt_cfg.div == ONE);
    end
  end
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
  import clk_ratio_pkg::*;
#(
  parameter logic [RATIO_W-1:0] RST_DIV = 1,
  parameter logic               RST_HW  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [RATIO_W-1:0] wr_div,
  input  logic               wr_hi_wide,
  input  logic               pll_busy_in,
  output logic               div_clk_out,
  output logic               pass_thru,
  output logic               busy,
  output logic               any_busy,
  output logic               wr_err
);
  ratio_cfg_t wr_cfg;
  ratio_cfg_t act_cfg;
  ratio_cfg_t nxt_cfg;
  logic       wrap;

  assign wr_cfg = '{div: wr_div, hi_wide: wr_hi_wide};

  clk_ratio_ctrl #(.RST_DIV(RST_DIV), .RST_HW(RST_HW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_cfg   (wr_cfg),
    .ext_busy (pll_busy_in),
    .wrap     (wrap),
    .act_cfg  (act_cfg),
    .nxt_cfg  (nxt_cfg),
    .busy_q   (busy),
    .any_q    (any_busy),
    .err_q    (wr_err)
  );

  clk_ratio_core #(.RST_DIV(RST_DIV)) u_core (
    .clk     (clk),
    .rst     (rst),
    .cur_cfg (act_cfg),
    .nxt_cfg (nxt_cfg),
    .wrap    (wrap),
    .phase_q (div_clk_out),
    .pass_q  (pass_thru)
  );
endmodule

// File: rtl/clk_ratio_gen_chk.sv
module clk_ratio_gen_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic pll_busy_in,
  input logic div_clk_out,
  input logic pass_thru,
  input logic busy,
  input logic any_busy,
  input logic wr_err
);
  AST_APPLY_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> div_clk_out); // R4
  AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy) |=> busy); // R3
  AST_SUMMARY_COVERS: assert property (@(posedge clk) disable iff (rst)
    busy |-> any_busy); // R6
  AST_EXT_SEEN: assert property (@(posedge clk) disable iff (rst)
    pll_busy_in |=> any_busy); // R6
  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> wr_err); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err); // R7
  AST_PASS_HIGH: assert property (@(posedge clk) disable iff (rst)
    pass_thru |-> div_clk_out); // R9
endmodule

bind clk_ratio_gen clk_ratio_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .pll_busy_in (pll_busy_in),
  .div_clk_out (div_clk_out),
  .pass_thru   (pass_thru),
  .busy        (busy),
  .any_busy    (any_busy),
  .wr_err      (wr_err)
);

// File: tb/clk_ratio_gen_tb.sv
`timescale 1ns/1ps
module clk_ratio_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_div = '0;
  logic       wr_hi_wide = 1'b0;
  logic       pll_busy_in = 1'b0;
  logic       div_clk_out, pass_thru, busy, any_busy, wr_err;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  clk_ratio_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_div(wr_div),
    .wr_hi_wide(wr_hi_wide), .pll_busy_in(pll_busy_in),
    .div_clk_out(div_clk_out), .pass_thru(pass_thru), .busy(busy),
    .any_busy(any_busy), .wr_err(wr_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; pll_busy_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle(input bit old_ge2);
    int n = 0;
    logic prev = div_clk_out;
    while (busy && n < 1000) begin
      prev = div_clk_out;
      @(negedge clk);
      n++;
    end
    check(div_clk_out == 1'b1, "R4 high at apply", div_clk_out, 1);
    if (old_ge2)
      check(prev == 1'b0, "R4 old period ends low", prev, 0);
  endtask

  task automatic measure(output int hi, output int lo);
    int n = 0;
    logic prev = div_clk_out;
    hi = 0; lo = 0;
    @(negedge clk);
    while (!(div_clk_out && !prev) && n < 1000) begin
      prev = div_clk_out; @(negedge clk); n++;
    end
    while (div_clk_out && hi < 1000) begin hi++; @(negedge clk); end
    while (!div_clk_out && lo < 1000) begin lo++; @(negedge clk); end
  endtask

  task automatic write_cfg(input logic [7:0] d, input logic hw);
    @(negedge clk); wr_en = 1'b1; wr_div = d; wr_hi_wide = hw;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check(busy == 0, "R8 busy", busy, 0);
    check(any_busy == 0, "R8 any_busy", any_busy, 0);
    check(wr_err == 0, "R8 wr_err", wr_err, 0);
    check(div_clk_out == 1, "R8 out", div_clk_out, 1);
    check(pass_thru == 1, "R8 pass", pass_thru, 1);
  endtask

  task automatic t_program(input logic [7:0] d, input logic hw, input bit old_ge2,
                           input int ehi, input int elo, input string req);
    int hi, lo;
    write_cfg(d, hw);
    check(busy == 1, "R3 busy after write", busy, 1);
    wait_idle(old_ge2);
    measure(hi, lo);
    check(hi == ehi, {req, " high length"}, hi, ehi);
    check(lo == elo, {req, " low length"}, lo, elo);
  endtask

  task automatic t_div1();
    bit ok = 1;
    write_cfg(8'd1, 1'b0);
    wait_idle(1'b1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!div_clk_out || !pass_thru) ok = 0;
    end
    check(ok, "R9 constant high with pass", ok, 1);
  endtask

  task automatic t_pll();
    @(negedge clk); pll_busy_in = 1'b1;
    @(negedge clk);
    check(any_busy == 1, "R6 external busy", any_busy, 1);
    check(busy == 0, "R6 own busy stays clear", busy, 0);
    pll_busy_in = 1'b0;
    @(negedge clk);
    check(any_busy == 0, "R6 external busy cleared", any_busy, 0);
  endtask

  task automatic t_collision();
    int hi, lo;
    check(wr_err == 0, "R7 no error before", wr_err, 0);
    @(negedge clk); wr_en = 1'b1; wr_div = 8'd6; wr_hi_wide = 1'b1;
    @(negedge clk); wr_div = 8'd2;
    @(negedge clk); wr_en = 1'b0;
    check(busy == 0, "R7 applied despite second write", busy, 0);
    check(wr_err == 1, "R7 error set", wr_err, 1);
    measure(hi, lo);
    check(hi == 3, "R7 first write kept high", hi, 3);
    check(lo == 3, "R7 first write kept low", lo, 3);
    repeat (5) @(negedge clk);
    check(wr_err == 1, "R7 error sticky", wr_err, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_program(8'd4, 1'b1, 1'b0, 2, 2, "R1 div4");
    t_program(8'd5, 1'b1, 1'b1, 3, 2, "R5 div5 hi-wide");
    t_program(8'd5, 1'b0, 1'b1, 2, 3, "R5 div5 lo-wide");
    t_program(8'd3, 1'b0, 1'b1, 1, 2, "R5 div3 lo-wide");
    t_program(8'd0, 1'b1, 1'b1, 128, 128, "R2 div256");
    t_program(8'd8, 1'b0, 1'b1, 4, 4, "R1 div8");
    t_div1();
    t_pll();
    do_reset();
    t_collision();
    do_reset();
    check(wr_err == 0, "R8 reset clears error", wr_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule